// File: doc/BRIEF.md
# CCD Sample and Clamp Strobe Sequencer

This block turns a video-sample request and a reset-level-clamp request into the internal strobes that a three-channel CCD analogue front end needs. All strobes are synchronous to one master clock. When a video-sample request is seen, the block starts a sequence that produces a reset-sample strobe at a programmable offset and a video-sample strobe at a fixed offset. A clamp request starts a separate delay that ends in a clamp strobe. That delay moves together with the reset-sample position, so the clamp always lands one cycle before the reset sample would.

The block also drives the select for the converter multiplexer shared by the red, green and blue channels. In pixel-interleaved mode the select steps after every completed video sample. In line-interleaved mode it holds and steps only on a line-advance pulse. Configuration bits can disable the reset-sample strobe (when correlated double sampling is bypassed) and the clamp strobe, each on its own.

Top module: `ccd_timing_gen`

## Requirements
- R1: All request inputs are sampled on the rising clock edge. If `vsmp_req` is high at edge k and the sequence is not restarted, `rs_strobe` is high for the single cycle that follows edge k+D, where D = 4 − `cfg_rs_pos` (codes 0,1,2,3 give 4,3,2,1).
- R2: With the same start, `vs_strobe` is high for the single cycle that follows edge k+6, for every `cfg_rs_pos` code.
- R3: Each of `rs_strobe`, `vs_strobe` and `cl_strobe` is high for exactly one clock cycle per event.
- R4: If `clamp_req` is high at edge m, `cl_strobe` is high for the single cycle that follows edge m+D−1 (three cycles at code 0, zero at code 3), one cycle earlier than the reset sample of a sequence started at the same edge.
- R5: A `vsmp_req` seen while a sequence is pending restarts it: the strobes of the earlier start do not appear, and both strobes follow the later start.
- R6: When `cfg_cds_byp` is 1, `rs_strobe` stays 0; `vs_strobe` is unaffected.
- R7: When `cfg_clamp_byp` is 1, `cl_strobe` stays 0.
- R8: `chan_sel` encodes R=0, G=1, B=2. With `cfg_line_mode` = 0 it steps R→G→B→R at the edge that ends each `vs_strobe` cycle, and `line_adv` is ignored.
- R9: With `cfg_line_mode` = 1, `chan_sel` holds through video samples and steps in the same order only at an edge where `line_adv` is high.
- R10: A synchronous active-high `rst` sets `chan_sel` to R, drives all strobes to 0 and cancels every pending sequence and clamp.
- R11: A `clamp_req` seen while a clamp is pending restarts the clamp delay; only one clamp strobe follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| vsmp_req | input | 1 | Video-sample request, starts a sequence |
| clamp_req | input | 1 | Reset-level clamp request |
| line_adv | input | 1 | Channel step pulse used in line mode |
| cfg_rs_pos | input | 2 | Reset-sample position code |
| cfg_line_mode | input | 1 | 1 = line-interleaved, 0 = pixel-interleaved |
| cfg_clamp_byp | input | 1 | 1 = suppress clamp strobe |
| cfg_cds_byp | input | 1 | 1 = suppress reset-sample strobe |
| rs_strobe | output | 1 | Reset-sample strobe |
| vs_strobe | output | 1 | Video-sample strobe |
| cl_strobe | output | 1 | Clamp strobe |
| chan_sel | output | 2 | Converter channel select (R=0, G=1, B=2) |

## Verification
The bench builds the block with its default parameters: a video-sample offset of six cycles and a reset-sample base offset of four, giving a three-bit sequence counter. These values bring every position code within reach, including code 3 where the clamp fires on the cycle right after its request, and they leave room to restart a sequence before its reset sample lands. Each code is run with and without each bypass, and the channel select is driven through its wrap in both interleave modes.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    typedef enum logic [1:0] {
        CH_R = 2'd0,
        CH_G = 2'd1,
        CH_B = 2'd2
    } chan_e;

    typedef struct packed {
        logic [1:0] rs_pos;
        logic       line_mode;
        logic       clamp_byp;
        logic       cds_byp;
    } tg_cfg_t;

    typedef struct packed {
        logic rs;
        logic vs;
        logic cl;
    } tg_strobe_t;

    localparam int RS_BASE_DLY_DEF = 4;
    localparam int VS_DLY_DEF      = 6;

    function automatic chan_e chan_next(chan_e cur);
        case (cur)
            CH_R:    return CH_G;
            CH_G:    return CH_B;
            default: return CH_R;
        endcase
    endfunction

endpackage

// File: rtl/ccd_seq_timer.sv
module ccd_seq_timer #(
    parameter int VS_DLY = 6,
    parameter int CNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] rs_dly,
    output logic             rs_hit,
    output logic             vs_hit
);
    localparam logic [CNT_W-1:0] VS_CNT = CNT_W'(VS_DLY);

    logic             busy;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt >= VS_CNT) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign rs_hit = busy && (cnt == rs_dly);
    assign vs_hit = busy && (cnt == VS_CNT);

endmodule

// File: rtl/ccd_clamp_timer.sv
module ccd_clamp_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] dly,
    output logic             cl_hit
);
    logic             armed;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (start) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed) begin
            if (cnt >= dly) begin
                armed <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign cl_hit = armed && (cnt == dly);

endmodule

// File: rtl/ccd_chan_sel.sv
module ccd_chan_sel
    import ccd_tg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  line_mode,
    input  logic  vs_done,
    input  logic  line_adv,
    output chan_e chan
);
    logic step;

    assign step = line_mode ? line_adv : vs_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan <= CH_R;
        end else if (step) begin
            chan <= chan_next(chan);
        end
    end

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
    import ccd_tg_pkg::*;
#(
    parameter int VS_DLY      = VS_DLY_DEF,
    parameter int RS_BASE_DLY = RS_BASE_DLY_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vsmp_req,
    input  logic       clamp_req,
    input  logic       line_adv,
    input  logic [1:0] cfg_rs_pos,
    input  logic       cfg_line_mode,
    input  logic       cfg_clamp_byp,
    input  logic       cfg_cds_byp,
    output logic       rs_strobe,
    output logic       vs_strobe,
    output logic       cl_strobe,
    output logic [1:0] chan_sel
);
    localparam int CNT_W = $clog2(VS_DLY + 1);

    tg_cfg_t          cfg;
    tg_strobe_t       hit;
    logic [CNT_W-1:0] rs_dly;
    logic [CNT_W-1:0] cl_dly;
    chan_e            chan;

    assign cfg = '{rs_pos:    cfg_rs_pos,
                   line_mode: cfg_line_mode,
                   clamp_byp: cfg_clamp_byp,
                   cds_byp:   cfg_cds_byp};

    // Clamp offset is tied to the reset-sample offset, one cycle earlier.
    assign rs_dly = CNT_W'(RS_BASE_DLY) - CNT_W'(cfg.rs_pos);
    assign cl_dly = rs_dly - 1'b1;

    ccd_seq_timer #(
        .VS_DLY (VS_DLY),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (vsmp_req),
        .rs_dly (rs_dly),
        .rs_hit (hit.rs),
        .vs_hit (hit.vs)
    );

    ccd_clamp_timer #(
        .CNT_W (CNT_W)
    ) u_clamp (
        .clk    (clk),
        .rst    (rst),
        .start  (clamp_req),
        .dly    (cl_dly),
        .cl_hit (hit.cl)
    );

    ccd_chan_sel u_chan (
        .clk       (clk),
        .rst       (rst),
        .line_mode (cfg.line_mode),
        .vs_done   (hit.vs),
        .line_adv  (line_adv),
        .chan      (chan)
    );

    assign rs_strobe = hit.rs && !cfg.cds_byp;
    assign vs_strobe = hit.vs;
    assign cl_strobe = hit.cl && !cfg.clamp_byp;
    assign chan_sel  = chan;

endmodule

// File: rtl/ccd_timing_gen_chk.sv
module ccd_timing_gen_chk
    import ccd_tg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       clamp_req,
    input logic       line_adv,
    input logic [1:0] cfg_rs_pos,
    input logic       cfg_line_mode,
    input logic       cfg_clamp_byp,
    input logic       cfg_cds_byp,
    input logic       rs_strobe,
    input logic       vs_strobe,
    input logic       cl_strobe,
    input logic [1:0] chan_sel
);
    // R3
    rs_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        rs_strobe |=> !rs_strobe || !$stable(cfg_rs_pos));

    // R3
    vs_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        vs_strobe |=> !vs_strobe);

    // R3
    cl_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        cl_strobe && !clamp_req |=> !cl_strobe || !$stable(cfg_rs_pos));

    // R6
    cds_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_cds_byp |-> !rs_strobe);

    // R7
    clamp_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_clamp_byp |-> !cl_strobe);

    // R8
    chan_legal_chk: assert property (@(posedge clk) disable iff (rst)
        chan_sel != 2'd3);

    // R8
    pixel_step_chk: assert property (@(posedge clk) disable iff (rst)
        vs_strobe && !cfg_line_mode |=>
            chan_sel == 2'(chan_next(chan_e'($past(chan_sel)))));

    // R9
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_line_mode && !line_adv |=> $stable(chan_sel));

endmodule

bind ccd_timing_gen ccd_timing_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .clamp_req     (clamp_req),
    .line_adv      (line_adv),
    .cfg_rs_pos    (cfg_rs_pos),
    .cfg_line_mode (cfg_line_mode),
    .cfg_clamp_byp (cfg_clamp_byp),
    .cfg_cds_byp   (cfg_cds_byp),
    .rs_strobe     (rs_strobe),
    .vs_strobe     (vs_strobe),
    .cl_strobe     (cl_strobe),
    .chan_sel      (chan_sel)
);

// File: tb/ccd_timing_gen_bench.sv
module ccd_timing_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vsmp_req = 1'b0;
    logic       clamp_req = 1'b0;
    logic       line_adv = 1'b0;
    logic [1:0] cfg_rs_pos = 2'd0;
    logic       cfg_line_mode = 1'b0;
    logic       cfg_clamp_byp = 1'b0;
    logic       cfg_cds_byp = 1'b0;
    logic       rs_strobe;
    logic       vs_strobe;
    logic       cl_strobe;
    logic [1:0] chan_sel;

    int n_vec  = 0;
    int n_fail = 0;
    int exp_chan = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ccd_timing_gen u_ccd_timing_gen (
        .clk           (clk),
        .rst           (rst),
        .vsmp_req      (vsmp_req),
        .clamp_req     (clamp_req),
        .line_adv      (line_adv),
        .cfg_rs_pos    (cfg_rs_pos),
        .cfg_line_mode (cfg_line_mode),
        .cfg_clamp_byp (cfg_clamp_byp),
        .cfg_cds_byp   (cfg_cds_byp),
        .rs_strobe     (rs_strobe),
        .vs_strobe     (vs_strobe),
        .cl_strobe     (cl_strobe),
        .chan_sel      (chan_sel)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nxt(input int c);
        return (c == 2) ? 0 : c + 1;
    endfunction

    // R10: reset state
    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 chan after reset", int'(chan_sel), 0);
        check("R10 rs after reset", int'(rs_strobe), 0);
        check("R10 vs after reset", int'(vs_strobe), 0);
        check("R10 cl after reset", int'(cl_strobe), 0);
        rst = 1'b0;
        exp_chan = 0;
        @(negedge clk);
    endtask

    // R1 R2 R3 R4 R6 R7 R8 R9: one sequence, sampled each cycle after start
    task automatic t_seq(input logic [1:0] code, input logic cbyp,
                         input logic rbyp, input logic with_cl);
        int d = 4 - int'(code);
        int n_rs = 0;
        int n_vs = 0;
        int n_cl = 0;
        int cur = exp_chan;
        int nx = cfg_line_mode ? exp_chan : nxt(exp_chan);
        cfg_rs_pos = code;
        cfg_clamp_byp = cbyp;
        cfg_cds_byp = rbyp;
        @(negedge clk);
        vsmp_req = 1'b1;
        clamp_req = with_cl;
        @(negedge clk);
        vsmp_req = 1'b0;
        clamp_req = 1'b0;
        for (int j = 0; j <= 9; j++) begin
            if (j > 0) @(negedge clk);
            n_rs += int'(rs_strobe);
            n_vs += int'(vs_strobe);
            n_cl += int'(cl_strobe);
            check(rbyp ? "R6 rs bypassed" : "R1 rs position",
                  int'(rs_strobe), int'(j == d && !rbyp));
            check("R2 vs position", int'(vs_strobe), int'(j == 6));
            check(cbyp ? "R7 cl bypassed" : "R4 cl position",
                  int'(cl_strobe), int'(with_cl && !cbyp && j == d - 1));
            check(cfg_line_mode ? "R9 chan held in line mode" : "R8 chan pixel step",
                  int'(chan_sel), (j >= 7) ? nx : cur);
        end
        check("R3 rs single pulse", n_rs, rbyp ? 0 : 1);
        check("R3 vs single pulse", n_vs, 1);
        check("R3 cl single pulse", n_cl, (with_cl && !cbyp) ? 1 : 0);
        exp_chan = nx;
        cfg_clamp_byp = 1'b0;
        cfg_cds_byp = 1'b0;
    endtask

    // R5: second request at edge k+3 with code 0
    task automatic t_restart();
        int cur = exp_chan;
        cfg_rs_pos = 2'd0;
        @(negedge clk);
        vsmp_req = 1'b1;
        @(negedge clk);
        vsmp_req = 1'b0;
        for (int j = 0; j <= 11; j++) begin
            if (j > 0) @(negedge clk);
            check("R5 rs after restart", int'(rs_strobe), int'(j == 7));
            check("R5 vs after restart", int'(vs_strobe), int'(j == 9));
            check("R5 chan after restart", int'(chan_sel), (j >= 10) ? nxt(cur) : cur);
            vsmp_req = (j == 2);
        end
        vsmp_req = 1'b0;
        exp_chan = nxt(cur);
    endtask

    // R11: clamp request at m and m+1, code 0
    task automatic t_clamp_restart();
        cfg_rs_pos = 2'd0;
        @(negedge clk);
        clamp_req = 1'b1;
        @(negedge clk);
        for (int j = 0; j <= 7; j++) begin
            if (j > 0) @(negedge clk);
            check("R11 cl after clamp restart", int'(cl_strobe), int'(j == 4));
            clamp_req = (j == 0);
        end
        clamp_req = 1'b0;
    endtask

    // R8 R9: line_adv behaviour in both modes
    task automatic t_line_adv(input logic line_mode);
        cfg_line_mode = line_mode;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            line_adv = 1'b1;
            @(negedge clk);
            line_adv = 1'b0;
            if (line_mode) exp_chan = nxt(exp_chan);
            check(line_mode ? "R9 line_adv steps chan" : "R8 line_adv ignored",
                  int'(chan_sel), exp_chan);
        end
    endtask

    // R10: reset in the middle of a sequence and a pending clamp
    task automatic t_mid_reset();
        cfg_rs_pos = 2'd0;
        @(negedge clk);
        vsmp_req = 1'b1;
        clamp_req = 1'b1;
        @(negedge clk);
        vsmp_req = 1'b0;
        clamp_req = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_chan = 0;
        for (int j = 0; j < 8; j++) begin
            check("R10 rs cleared", int'(rs_strobe), 0);
            check("R10 vs cleared", int'(vs_strobe), 0);
            check("R10 cl cleared", int'(cl_strobe), 0);
            check("R10 chan cleared", int'(chan_sel), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        t_reset_state();
        for (int c = 0; c < 4; c++) begin
            t_seq(2'(c), 1'b0, 1'b0, 1'b1);
            t_seq(2'(c), 1'b1, 1'b0, 1'b1);
            t_seq(2'(c), 1'b0, 1'b1, 1'b1);
            t_seq(2'(c), 1'b1, 1'b1, 1'b0);
        end
        t_restart();
        t_clamp_restart();
        t_line_adv(1'b0);
        cfg_line_mode = 1'b1;
        t_seq(2'd1, 1'b0, 1'b0, 1'b0);
        t_line_adv(1'b1);
        cfg_line_mode = 1'b0;
        t_seq(2'd2, 1'b0, 1'b0, 1'b0);
        t_mid_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule